// File: doc/BRIEF.md
# Remote DMA data port engine

This block lets a host move bytes into and out of a local packet memory through a single data port register. The host first writes a 16-bit memory address and a 16-bit byte count, each as a low byte and a high byte. Each later access to the data port then moves one, two or four bytes. It moves them between the host bus and the local memory port, steps the address with wrap-around inside a receive ring, and lowers the count. When the count is used up, a completion status bit and the interrupt line rise.

The host bus has no wait states. Register and data port reads return data in the same cycle through a combinational path, and every side effect takes place at the clock edge that ends the access. The local memory port is also combinational: the block presents a byte address with a lane-enable mask, and lane i of the data bus is the byte at that address plus i. The ring bounds come in as inputs. Only a small low region and a packet window are reachable through the data port.

Top module: `rdma_port`

## Requirements
- R1: After reset, the address (offsets 1, 2), count (offsets 3, 4), configuration (offset 5) and status (offset 6) registers read 0, and `irq` is low.
- R2: Writing offset 1 or 2 replaces the low or high byte of the current address. Writing offset 3 or 4 replaces the low or high byte of the count. The other byte is kept, and reads of the same offsets return the live values.
- R3: A data port access (offset 8) moves 4 bytes when `host_wide` is set. Otherwise it moves 2 bytes when configuration bit 0 is set, and 1 byte when that bit is clear. The lane mask is 0001, 0011 or 1111 and the byte order is little-endian. Reads return the moved bytes zero-extended.
- R4: Each data port access advances the current address by the transfer size. If the result equals `ring_stop`, the address is reloaded from `ring_start`.
- R5: If the count is greater than the transfer size, an access lowers it by that size. Otherwise the count becomes 0 and status bit 6 (value 0x40) is set, which drives `irq` high.
- R6: A command write (offset 0) with bit 3 or bit 4 set and bit 0 clear, made while the count is 0, sets status bit 6 at once. With bit 0 set, it has no such effect.
- R7: A data port write while the count is 0 is ignored: there is no memory write, and neither the address nor the count changes.
- R8: For 2-byte and 4-byte transfers, the memory address has bit 0 cleared. The address register itself still advances from its unaligned value.
- R9: Only addresses below 32, and transfers lying entirely within [0x4000, 0x8000), reach memory. Reads elsewhere return all ones of the transfer size. Writes elsewhere are dropped, but the address and the count still advance.
- R10: Writing a 1 to bit 6 of the status register (offset 6) clears the completion bit, and `irq` falls.
- R11: A data port read while the count is 0 still returns data and advances the address. It leaves the count at 0 and sets status bit 6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_sel | input | 1 | Host access in this cycle |
| host_wr | input | 1 | 1 = write, 0 = read |
| host_addr | input | 4 | Register offset (8 = data port) |
| host_wide | input | 1 | Data port access is 4 bytes |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Host read data (combinational) |
| ring_start | input | 16 | Ring start address |
| ring_stop | input | 16 | Ring stop address (exclusive) |
| mem_addr | output | 16 | Local memory byte address |
| mem_we | output | 1 | Local memory write strobe |
| mem_wbe | output | 4 | Byte lane enables |
| mem_wdata | output | 32 | Local memory write data |
| mem_rdata | input | 32 | Local memory read data (combinational) |
| irq | output | 1 | Transfer complete interrupt |

## Verification
A wrong address or count register shows up at the very next access. It appears on `mem_addr` as a wrong strobe location, or on the readback of offsets 1 to 4 one cycle after the access edge. A count that is off by one shifts the completion event by one access, so the status readback and `irq` appear either early or late. The checks for these read back the status at the exact access where the count runs out. A wrong size decode appears in the same cycle as a bad lane mask or a wrongly masked read value.

// File: rtl/rdma_port.sv
module rdma_port #(
  parameter int LOW_SPAN = 32,
  parameter int WIN_BASE = 'h4000,
  parameter int WIN_END  = 'h8000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        host_sel,
  input  logic        host_wr,
  input  logic [3:0]  host_addr,
  input  logic        host_wide,
  input  logic [31:0] host_wdata,
  output logic [31:0] host_rdata,
  input  logic [15:0] ring_start,
  input  logic [15:0] ring_stop,
  output logic [15:0] mem_addr,
  output logic        mem_we,
  output logic [3:0]  mem_wbe,
  output logic [31:0] mem_wdata,
  input  logic [31:0] mem_rdata,
  output logic        irq
);
  localparam logic [16:0] LOW_L  = 17'(LOW_SPAN);
  localparam logic [16:0] BASE_L = 17'(WIN_BASE);
  localparam logic [16:0] END_L  = 17'(WIN_END);
  localparam logic [3:0]  OFS_CMD = 4'd0, OFS_ALO = 4'd1, OFS_AHI = 4'd2,
                          OFS_CLO = 4'd3, OFS_CHI = 4'd4, OFS_CFG = 4'd5,
                          OFS_STS = 4'd6, OFS_DAT = 4'd8;

  logic [7:0]  cmd_q;
  logic [15:0] cur_addr, count;
  logic        cfg_word, done;

  logic [2:0]  xfer_n;
  logic [15:0] eff, nxt;
  logic [16:0] eff_ext;
  logic        in_win, port_hit, take, wr_acc;
  logic [31:0] dmask;

  assign xfer_n   = host_wide ? 3'd4 : (cfg_word ? 3'd2 : 3'd1);
  assign eff      = (xfer_n == 3'd1) ? cur_addr : {cur_addr[15:1], 1'b0};
  assign eff_ext  = {1'b0, eff};
  assign in_win   = (eff_ext < LOW_L) ||
                    (eff_ext >= BASE_L && eff_ext + 17'(xfer_n) <= END_L);
  assign port_hit = host_sel && host_addr == OFS_DAT;
  assign take     = port_hit && (!host_wr || count != 16'd0);
  assign wr_acc   = host_sel && host_wr;
  assign nxt      = cur_addr + 16'(xfer_n);
  assign dmask    = (xfer_n == 3'd4) ? 32'hFFFF_FFFF :
                    (xfer_n == 3'd2) ? 32'h0000_FFFF : 32'h0000_00FF;

  assign mem_addr  = eff;
  assign mem_we    = take && host_wr && in_win;
  assign mem_wbe   = (xfer_n == 3'd4) ? 4'hF : (xfer_n == 3'd2) ? 4'h3 : 4'h1;
  assign mem_wdata = host_wdata;
  assign irq       = done;

  always_comb begin
    case (host_addr)
      OFS_CMD: host_rdata = {24'd0, cmd_q};
      OFS_ALO: host_rdata = {24'd0, cur_addr[7:0]};
      OFS_AHI: host_rdata = {24'd0, cur_addr[15:8]};
      OFS_CLO: host_rdata = {24'd0, count[7:0]};
      OFS_CHI: host_rdata = {24'd0, count[15:8]};
      OFS_CFG: host_rdata = {31'd0, cfg_word};
      OFS_STS: host_rdata = {25'd0, done, 6'd0};
      OFS_DAT: host_rdata = in_win ? (mem_rdata & dmask) : dmask;
      default: host_rdata = 32'd0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q    <= 8'd0;
      cur_addr <= 16'd0;
      count    <= 16'd0;
      cfg_word <= 1'b0;
      done     <= 1'b0;
    end else begin
      if (take) begin
        cur_addr <= (nxt == ring_stop) ? ring_start : nxt;
        if (count <= 16'(xfer_n)) begin
          count <= 16'd0;
          done  <= 1'b1;
        end else begin
          count <= count - 16'(xfer_n);
        end
      end
      if (wr_acc) begin
        case (host_addr)
          OFS_CMD: begin
            cmd_q <= host_wdata[7:0];
            if (!host_wdata[0] && (host_wdata[3] || host_wdata[4]) && count == 16'd0)
              done <= 1'b1;
          end
          OFS_ALO: cur_addr[7:0]  <= host_wdata[7:0];
          OFS_AHI: cur_addr[15:8] <= host_wdata[7:0];
          OFS_CLO: count[7:0]     <= host_wdata[7:0];
          OFS_CHI: count[15:8]    <= host_wdata[7:0];
          OFS_CFG: cfg_word       <= host_wdata[0];
          OFS_STS: if (host_wdata[6]) done <= 1'b0;
          default: ;
        endcase
      end
    end
  end
endmodule

module rdma_port_chk #(
  parameter int LOW_SPAN = 32,
  parameter int WIN_BASE = 'h4000
) (
  input logic        clk,
  input logic        rst_n,
  input logic        host_sel,
  input logic        host_wr,
  input logic [3:0]  host_addr,
  input logic [31:0] host_wdata,
  input logic [15:0] ring_start,
  input logic [15:0] ring_stop,
  input logic [15:0] mem_addr,
  input logic        mem_we,
  input logic        irq,
  input logic [15:0] cur_addr,
  input logic [15:0] count,
  input logic [2:0]  xfer_n
);
  logic acc;
  assign acc = host_sel && host_addr == 4'd8 && (!host_wr || count != 16'd0);

  AST_WR_NEEDS_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> count != 16'd0); // R7
  AST_ALIGNED_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && xfer_n != 3'd1) |-> !mem_addr[0]); // R8
  AST_EXHAUST: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && count <= 16'(xfer_n)) |=> (irq && count == 16'd0)); // R5
  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && count > 16'(xfer_n)) |=> count == $past(count) - 16'($past(xfer_n))); // R5
  AST_RING_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && cur_addr + 16'(xfer_n) == ring_stop) |=> cur_addr == $past(ring_start)); // R4
  AST_ZERO_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    (host_sel && host_wr && host_addr == 4'd0 && !host_wdata[0] &&
     (host_wdata[3] || host_wdata[4]) && count == 16'd0) |=> irq); // R6
  AST_WINDOW_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (32'(mem_addr) < LOW_SPAN || 32'(mem_addr) >= WIN_BASE)); // R9
endmodule

bind rdma_port rdma_port_chk #(.LOW_SPAN(LOW_SPAN), .WIN_BASE(WIN_BASE)) u_chk (
  .clk(clk), .rst_n(rst_n), .host_sel(host_sel), .host_wr(host_wr),
  .host_addr(host_addr), .host_wdata(host_wdata), .ring_start(ring_start),
  .ring_stop(ring_stop), .mem_addr(mem_addr), .mem_we(mem_we), .irq(irq),
  .cur_addr(cur_addr), .count(count), .xfer_n(xfer_n)
);

// File: tb/rdma_port_bench.sv
`timescale 1ns/1ps
module rdma_port_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_sel = 1'b0, host_wr = 1'b0, host_wide = 1'b0;
  logic [3:0]  host_addr = 4'd0;
  logic [31:0] host_wdata = 32'd0;
  logic [31:0] host_rdata;
  logic [15:0] ring_start = 16'h4000, ring_stop = 16'h4100;
  logic [15:0] mem_addr;
  logic        mem_we;
  logic [3:0]  mem_wbe;
  logic [31:0] mem_wdata, mem_rdata;
  logic        irq;

  int vectors = 0, errors = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  rdma_port u_rdma_port (
    .clk(clk), .rst_n(rst_n), .host_sel(host_sel), .host_wr(host_wr),
    .host_addr(host_addr), .host_wide(host_wide), .host_wdata(host_wdata),
    .host_rdata(host_rdata), .ring_start(ring_start), .ring_stop(ring_stop),
    .mem_addr(mem_addr), .mem_we(mem_we), .mem_wbe(mem_wbe),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .irq(irq)
  );

  logic [7:0] mem_m [0:65535];
  initial for (int i = 0; i < 65536; i++) mem_m[i] = 8'd0;
  assign mem_rdata = {mem_m[16'(mem_addr + 16'd3)], mem_m[16'(mem_addr + 16'd2)],
                      mem_m[16'(mem_addr + 16'd1)], mem_m[mem_addr]};
  always @(posedge clk)
    if (mem_we)
      for (int i = 0; i < 4; i++)
        if (mem_wbe[i]) mem_m[16'(mem_addr + 16'(i))] <= mem_wdata[8*i +: 8];

  typedef struct {
    bit          is_wr;
    logic [31:0] exp;
    logic        ewe;
    logic [15:0] eaddr;
    logic [3:0]  ebe;
    string       tag;
  } item_t;
  item_t sb[$];

  always begin
    @(negedge clk);
    #2;
    if (host_sel && sb.size() > 0) begin
      item_t it;
      it = sb.pop_front();
      vectors++;
      if (!it.is_wr) begin
        if (host_rdata !== it.exp) begin
          errors++;
          $display("FAIL %s: rdata actual %h expected %h", it.tag, host_rdata, it.exp);
        end
      end else if (mem_we !== it.ewe ||
                   (it.ewe && (mem_addr !== it.eaddr || mem_wbe !== it.ebe))) begin
        errors++;
        $display("FAIL %s: we/addr/be actual %b/%h/%b expected %b/%h/%b",
                 it.tag, mem_we, mem_addr, mem_wbe, it.ewe, it.eaddr, it.ebe);
      end
    end
  end

  task automatic drive(input bit wr, input [3:0] a, input bit wide, input [31:0] d);
    @(negedge clk);
    host_sel = 1'b1; host_wr = wr; host_addr = a; host_wide = wide; host_wdata = d;
    @(negedge clk);
    host_sel = 1'b0;
  endtask

  task automatic wreg(input [3:0] a, input [7:0] d);
    drive(1'b1, a, 1'b0, {24'd0, d});
  endtask

  task automatic rreg(input [3:0] a, input [7:0] e, input string tag);
    item_t it;
    it.is_wr = 0; it.exp = {24'd0, e}; it.ewe = 0; it.eaddr = 0; it.ebe = 0; it.tag = tag;
    sb.push_back(it);
    drive(1'b0, a, 1'b0, 32'd0);
  endtask

  task automatic rdat(input bit wide, input [31:0] e, input string tag);
    item_t it;
    it.is_wr = 0; it.exp = e; it.ewe = 0; it.eaddr = 0; it.ebe = 0; it.tag = tag;
    sb.push_back(it);
    drive(1'b0, 4'd8, wide, 32'd0);
  endtask

  task automatic wdat(input [31:0] d, input bit wide, input bit we,
                      input [15:0] ea, input [3:0] be, input string tag);
    item_t it;
    it.is_wr = 1; it.exp = 0; it.ewe = we; it.eaddr = ea; it.ebe = be; it.tag = tag;
    sb.push_back(it);
    drive(1'b1, 4'd8, wide, d);
  endtask

  task automatic chk_irq(input bit e, input string tag);
    @(negedge clk);
    #2;
    vectors++;
    if (irq !== e) begin
      errors++;
      $display("FAIL %s: irq actual %b expected %b", tag, irq, e);
    end
  endtask

  task automatic set_addr(input [15:0] a);
    wreg(4'd1, a[7:0]); wreg(4'd2, a[15:8]);
  endtask

  task automatic set_cnt(input [15:0] c);
    wreg(4'd3, c[7:0]); wreg(4'd4, c[15:8]);
  endtask

  initial begin
    #200000;
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    rreg(4'd1, 8'h00, "R1"); rreg(4'd2, 8'h00, "R1");
    rreg(4'd3, 8'h00, "R1"); rreg(4'd4, 8'h00, "R1");
    rreg(4'd5, 8'h00, "R1"); rreg(4'd6, 8'h00, "R1");
    chk_irq(1'b0, "R1");
    // R2 split byte registers
    wreg(4'd1, 8'h34); wreg(4'd2, 8'h12);
    rreg(4'd1, 8'h34, "R2"); rreg(4'd2, 8'h12, "R2");
    wreg(4'd1, 8'h56);
    rreg(4'd2, 8'h12, "R2"); rreg(4'd1, 8'h56, "R2");
    set_cnt(16'h0105); wreg(4'd3, 8'h07);
    rreg(4'd4, 8'h01, "R2"); rreg(4'd3, 8'h07, "R2");
    // R3 byte write, R4/R5 step
    set_addr(16'h4000); set_cnt(16'd3); wreg(4'd5, 8'h00);
    wdat(32'h0000_00AB, 1'b0, 1'b1, 16'h4000, 4'b0001, "R3");
    rreg(4'd1, 8'h01, "R4"); rreg(4'd3, 8'h02, "R5");
    // R8 word write from odd address, R5 exhaust
    wreg(4'd5, 8'h01);
    wdat(32'h0000_BEEF, 1'b0, 1'b1, 16'h4000, 4'b0011, "R8");
    rreg(4'd1, 8'h03, "R4"); rreg(4'd3, 8'h00, "R5");
    rreg(4'd6, 8'h40, "R5"); chk_irq(1'b1, "R5");
    // R7 write ignored at zero count
    wdat(32'h0000_1234, 1'b0, 1'b0, 16'h0000, 4'b0000, "R7");
    rreg(4'd1, 8'h03, "R7"); rreg(4'd3, 8'h00, "R7");
    // R10 status clear
    wreg(4'd6, 8'h40);
    rreg(4'd6, 8'h00, "R10"); chk_irq(1'b0, "R10");
    // R6 zero-count command
    wreg(4'd0, 8'h0A);
    rreg(4'd6, 8'h40, "R6");
    wreg(4'd6, 8'h40); wreg(4'd0, 8'h09);
    rreg(4'd6, 8'h00, "R6");
    // R3 readback in word and byte mode
    set_addr(16'h4000); set_cnt(16'd4);
    rdat(1'b0, 32'h0000_BEEF, "R3");
    wreg(4'd5, 8'h00); set_addr(16'h4000);
    rdat(1'b0, 32'h0000_00EF, "R3");
    // R3/R8 doubleword
    set_addr(16'h4011); set_cnt(16'd8);
    wdat(32'h1122_3344, 1'b1, 1'b1, 16'h4010, 4'b1111, "R8");
    rreg(4'd1, 8'h15, "R4");
    set_addr(16'h4010);
    rdat(1'b1, 32'h1122_3344, "R3");
    rreg(4'd6, 8'h40, "R5");
    wreg(4'd6, 8'h40);
    // R4 ring wrap
    wreg(4'd5, 8'h01); set_addr(16'h40FE); set_cnt(16'd8);
    wdat(32'h0000_CAFE, 1'b0, 1'b1, 16'h40FE, 4'b0011, "R4");
    rreg(4'd1, 8'h00, "R4"); rreg(4'd2, 8'h40, "R4");
    set_addr(16'h40FC);
    rdat(1'b1, 32'hCAFE_0000, "R4");
    rreg(4'd2, 8'h40, "R4"); rreg(4'd1, 8'h00, "R4");
    // R9 outside the valid regions
    wreg(4'd5, 8'h00); set_addr(16'h2000); set_cnt(16'd16);
    rdat(1'b0, 32'h0000_00FF, "R9");
    wreg(4'd5, 8'h01);
    rdat(1'b0, 32'h0000_FFFF, "R9");
    rdat(1'b1, 32'hFFFF_FFFF, "R9");
    wdat(32'h0000_0077, 1'b0, 1'b0, 16'h0000, 4'b0000, "R9");
    rreg(4'd1, 8'h09, "R9"); rreg(4'd3, 8'h07, "R9");
    wreg(4'd5, 8'h00); set_addr(16'h0010);
    wdat(32'h0000_005A, 1'b0, 1'b1, 16'h0010, 4'b0001, "R9");
    set_addr(16'h7FFE);
    rdat(1'b1, 32'hFFFF_FFFF, "R9");
    // R11 read at zero count
    wreg(4'd6, 8'h40); set_cnt(16'd0); set_addr(16'h4020);
    rdat(1'b0, 32'h0000_0000, "R11");
    rreg(4'd1, 8'h21, "R11"); rreg(4'd6, 8'h40, "R11"); rreg(4'd3, 8'h00, "R11");
    repeat (2) @(negedge clk);
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule